// File: doc/BRIEF.md
# Condition-Driven Early-Exit Vector Loop Controller

This block steps through the elements of a vector operation one per clock, in program order from element 0 up to the requested length minus one. For each element the execution datapath hands back a 4-bit condition field computed from that element's result. The controller applies a single-bit test to that field, one element at a time. From the outcome it decides three things: whether the element's data result may be written, whether its condition field is stored, and whether the loop stops at that element.

When the test fails, the loop stops at once. No later element writes, and the vector length reported at the end is cut to the failing index. If the inclusive option is set, the failing element is counted too. A length of zero is a legal result. A length shorter than requested is reported only when a test fails. Elements switched off by the predicate mask are passed over and never tested.

Mode bits, length and predicate are captured when `start_i` is accepted. The condition field for the current element must be valid during the cycle in which that element is presented on `elem_o`. The write enables for that element are combinational in that same cycle.

Top module: `ffirst_loop_ctrl`

## Requirements
- R1: After an accepted start with non-zero length, `busy_o` is high in the next cycle with `elem_o`=0. `elem_o` then rises by exactly one each cycle while `busy_o` stays high.
- R2: The condition field is {lt,gt,eq,so} on bits [3:0]. With `rc_i`=1, `sel_i` values 0,1,2,3 select lt, gt, eq, so. An active element fails when the selected bit equals `inv_i`.
- R3: With `rc_i`=0 the tested bit is always eq (bit 1), whatever the value of `sel_i`.
- R4: When element i fails, no element above i is presented or written. `busy_o` falls and `done_o` pulses in the next cycle.
- R5: After a failure at element i, `vl_o` is i when the effective inclusive flag is clear and i+1 when it is set. The inclusive flag `incl_i` takes effect only when `rc_i`=0.
- R6: For the failing element, `reg_we_o` equals the effective inclusive flag. For an active element that passes, `reg_we_o` is 1 unless compare-only is in effect.
- R7: Compare-only (`cmp_only_i`=1 with `rc_i`=0) forces `reg_we_o`=0 and `cr_we_o`=1 on every active element. With `rc_i`=1, `cmp_only_i` has no effect and `cr_we_o`=1 on every active element. With `rc_i`=0 and compare-only clear, `cr_we_o`=0.
- R8: A start with length 0 gives `done_o` in the next cycle with `vl_o`=0. A failure at element 0 with the inclusive flag clear also gives `vl_o`=0.
- R9: An element whose predicate bit is 0 gets `reg_we_o`=0 and `cr_we_o`=0, and it never ends the loop.
- R10: If no element fails, `vl_o` equals the requested length and `done_o` pulses in the cycle after the last element.
- R11: During and after reset, `busy_o`, `done_o`, `reg_we_o`, `cr_we_o` and `vl_o` are all 0.
- R12: A `start_i` that arrives while `busy_o` is high is ignored. The run in progress keeps its length, mode and element sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a loop; accepted only when idle |
| vl_i | input | VLW | Requested vector length (0..MAX_VL) |
| pred_i | input | MAX_VL | Predicate mask, one bit per element |
| inv_i | input | 1 | Test fails when selected bit equals this |
| sel_i | input | 2 | Condition bit select (used when rc_i=1) |
| incl_i | input | 1 | Count the failing element (rc_i=0 only) |
| cmp_only_i | input | 1 | Store condition only, never data (rc_i=0 only) |
| rc_i | input | 1 | Record-condition form of the operation |
| cond_i | input | 4 | Condition field {lt,gt,eq,so} of current element |
| busy_o | output | 1 | An element is being presented this cycle |
| elem_o | output | IW | Index of the current element |
| reg_we_o | output | 1 | Data result write enable for current element |
| cr_we_o | output | 1 | Condition field write enable for current element |
| done_o | output | 1 | One-cycle pulse: loop finished, vl_o valid |
| vl_o | output | VLW | Resulting vector length |

## Verification
Write enables depend on `cond_i` and on state captured at the previous edge, with no register in between. They are therefore due in the same cycle as the element they refer to. The bench drives each condition field at the falling edge and samples the enables one time step later, before the next rising edge. `done_o` and `vl_o` are registered: they appear one rising edge after the last presented element, or after the start edge for a length of zero. The bench samples them at the falling edge that follows. The sweep covers every mode combination against lengths 0 to MAX_VL, several predicate masks and several condition patterns, and compares each sample with a model built from the requirements.

// File: rtl/ffirst_pkg.sv
package ffirst_pkg;

  localparam int unsigned CondW = 4;
  localparam logic [1:0] EqSel = 2'd2;

  typedef struct packed {
    logic       inv;
    logic [1:0] sel;
    logic       incl;
    logic       cmp_only;
    logic       rc;
  } ff_mode_t;

  // bit layout {lt,gt,eq,so}: select 0 -> bit 3 ... select 3 -> bit 0
  function automatic logic pick_cond(input logic [CondW-1:0] c, input logic [1:0] s);
    return c[2'd3 - s];
  endfunction

endpackage

// File: rtl/ffirst_test.sv
module ffirst_test
  import ffirst_pkg::*;
(
  input  ff_mode_t         mode_i,
  input  logic             active_i,
  input  logic [CondW-1:0] cond_i,
  output logic             fail_o,
  output logic             incl_o,
  output logic             reg_we_o,
  output logic             cr_we_o
);

  logic [1:0] eff_sel;
  logic       tested;
  logic       cmp_eff;

  always_comb begin
    eff_sel  = mode_i.rc ? mode_i.sel : EqSel;
    tested   = pick_cond(cond_i, eff_sel);
    incl_o   = ~mode_i.rc & mode_i.incl;
    cmp_eff  = ~mode_i.rc & mode_i.cmp_only;
    fail_o   = active_i & (tested == mode_i.inv);
    reg_we_o = active_i & ~cmp_eff & (~fail_o | incl_o);
    cr_we_o  = active_i & (mode_i.rc | cmp_eff);
  end

endmodule

// File: rtl/ffirst_seq.sv
module ffirst_seq #(
  parameter int unsigned MAX_VL = 8,
  localparam int unsigned IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int unsigned VLW = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic              fail_i,
  input  logic              incl_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              active_o,
  output logic [IW-1:0]     idx_o,
  output logic              done_o,
  output logic [VLW-1:0]    vl_o
);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [VLW-1:0]    len_q, len_d;
  logic [VLW-1:0]    vlo_q, vlo_d;
  logic [MAX_VL-1:0] pred_q, pred_d;
  logic              step_en;
  logic              last;
  logic [VLW-1:0]    idx_ext;

  assign accept_o = start_i & ~busy_q;
  assign idx_ext  = VLW'(idx_q);
  assign last     = (idx_ext + VLW'(1)) == len_q;
  assign active_o = busy_q & pred_q[idx_q];
  assign step_en  = accept_o | busy_q | done_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    len_d  = len_q;
    vlo_d  = vlo_q;
    pred_d = pred_q;
    if (accept_o) begin
      len_d  = vl_i;
      pred_d = pred_i;
      idx_d  = '0;
      if (vl_i == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        vlo_d  = '0;
      end else begin
        busy_d = 1'b1;
      end
    end else if (busy_q) begin
      if (fail_i) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        vlo_d  = idx_ext + VLW'(incl_i);
      end else if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        vlo_d  = len_q;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      vlo_q  <= '0;
      pred_q <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      vlo_q  <= vlo_d;
      pred_q <= pred_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign vl_o   = vlo_q;

  // R1
  elem_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> idx_q == $past(idx_q) + IW'(1));

  // R4
  fail_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && fail_i |=> !busy_q && done_q);

  // R10
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> vlo_q <= len_q);

  // R12
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !fail_i && !last |=> busy_q && len_q == $past(len_q));

endmodule

// File: rtl/ffirst_loop_ctrl.sv
module ffirst_loop_ctrl
  import ffirst_pkg::*;
#(
  parameter int unsigned MAX_VL = 8,
  localparam int unsigned IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int unsigned VLW = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic              inv_i,
  input  logic [1:0]        sel_i,
  input  logic              incl_i,
  input  logic              cmp_only_i,
  input  logic              rc_i,
  input  logic [3:0]        cond_i,
  output logic              busy_o,
  output logic [IW-1:0]     elem_o,
  output logic              reg_we_o,
  output logic              cr_we_o,
  output logic              done_o,
  output logic [VLW-1:0]    vl_o
);

  ff_mode_t mode_q, mode_d;
  logic     accept;
  logic     active;
  logic     fail;
  logic     incl_eff;

  always_comb begin
    mode_d = mode_q;
    if (accept) begin
      mode_d = '{inv: inv_i, sel: sel_i, incl: incl_i,
                 cmp_only: cmp_only_i, rc: rc_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (accept) begin
      mode_q <= mode_d;
    end
  end

  ffirst_test u_test (
    .mode_i   (mode_q),
    .active_i (active),
    .cond_i   (cond_i),
    .fail_o   (fail),
    .incl_o   (incl_eff),
    .reg_we_o (reg_we_o),
    .cr_we_o  (cr_we_o)
  );

  ffirst_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .pred_i   (pred_i),
    .fail_i   (fail),
    .incl_i   (incl_eff),
    .accept_o (accept),
    .busy_o   (busy_o),
    .active_o (active),
    .idx_o    (elem_o),
    .done_o   (done_o),
    .vl_o     (vl_o)
  );

  // R9
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !reg_we_o && !cr_we_o && !fail);

  // R7
  cmp_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && mode_q.cmp_only && !mode_q.rc |-> !reg_we_o && cr_we_o);

  // R6
  fail_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail && !(mode_q.cmp_only && !mode_q.rc) |-> reg_we_o == (mode_q.incl && !mode_q.rc));

endmodule

// File: tb/test_ffirst_loop_ctrl.sv
module test_ffirst_loop_ctrl;

  localparam int unsigned MAX_VL = 8;
  localparam int unsigned IW  = $clog2(MAX_VL);
  localparam int unsigned VLW = $clog2(MAX_VL + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [VLW-1:0]    vl = '0;
  logic [MAX_VL-1:0] pred = '0;
  logic              inv = 1'b0;
  logic [1:0]        sel = '0;
  logic              incl = 1'b0;
  logic              cmp = 1'b0;
  logic              rc = 1'b0;
  logic [3:0]        cond = '0;
  logic              busy, reg_we, cr_we, done;
  logic [IW-1:0]     elem;
  logic [VLW-1:0]    vl_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  ffirst_loop_ctrl #(.MAX_VL(MAX_VL)) i_ffirst_loop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .pred_i(pred),
    .inv_i(inv), .sel_i(sel), .incl_i(incl), .cmp_only_i(cmp), .rc_i(rc),
    .cond_i(cond), .busy_o(busy), .elem_o(elem), .reg_we_o(reg_we),
    .cr_we_o(cr_we), .done_o(done), .vl_o(vl_out)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // pat 0: all pass, 1: fail at last, 2: fail at first, 3: pseudo-random
  task automatic run(input int n, input logic [MAX_VL-1:0] pm, input logic i_inv,
                     input logic [1:0] i_sel, input logic i_incl, input logic i_cmp,
                     input logic i_rc, input int pat);
    logic [3:0] cs [MAX_VL];
    logic [3:0] passv, failv;
    int exp_vl;
    passv = i_inv ? 4'h0 : 4'hF;
    failv = i_inv ? 4'hF : 4'h0;
    for (int k = 0; k < MAX_VL; k++) begin
      step_lfsr();
      case (pat)
        0: cs[k] = passv;
        1: cs[k] = (k == n - 1) ? failv : passv;
        2: cs[k] = (k == 0) ? failv : passv;
        default: cs[k] = lfsr[3:0] | ((lfsr[7:4] == 4'h0) ? 4'h0 : passv & {2'b00, lfsr[8], 1'b0});
      endcase
    end
    start = 1'b1; vl = VLW'(n); pred = pm; inv = i_inv; sel = i_sel;
    incl = i_incl; cmp = i_cmp; rc = i_rc;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    exp_vl = n;
    for (int k = 0; k < n; k++) begin
      logic act, bitv, f, ie, ce, er, ec;
      if (k > 0) @(negedge clk);
      cond = cs[k];
      #0.5;
      act  = pm[k];
      bitv = i_rc ? cs[k][3 - i_sel] : cs[k][1];   // R2 R3
      f    = act && (bitv == i_inv);
      ie   = !i_rc && i_incl;
      ce   = !i_rc && i_cmp;
      er   = act && !ce && (!f || ie);             // R6 R7 R9
      ec   = act && (i_rc || ce);                  // R7
      check("R1", busy, 1, "busy during element");
      check("R1", elem, k, "element index");
      check(f ? "R6" : "R9", reg_we, er, "reg write enable");
      check("R7", cr_we, ec, "cond write enable");
      if (f) begin
        exp_vl = k + (ie ? 1 : 0);
        break;
      end
    end
    if (n > 0) @(negedge clk);
    check("R4", busy, 0, "busy after loop");
    check("R10", done, 1, "done pulse");
    check((exp_vl == 0) ? "R8" : "R5", vl_out, exp_vl, "result length");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL R1 watchdog: cycles %0d expected below 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    check("R11", busy, 0, "reset busy");
    check("R11", done, 0, "reset done");
    check("R11", vl_out, 0, "reset length");
    check("R11", reg_we | cr_we, 0, "reset write enables");
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 2; r++)
      for (int iv = 0; iv < 2; iv++)
        for (int s = 0; s < 4; s++)
          for (int ic = 0; ic < 2; ic++)
            for (int cm = 0; cm < 2; cm++)
              for (int n = 0; n <= MAX_VL; n++)
                for (int p = 0; p < 4; p++)
                  for (int m = 0; m < 2; m++) begin
                    step_lfsr();
                    run(n, (m == 0) ? '1 : lfsr[MAX_VL-1:0], iv[0], s[1:0],
                        ic[0], cm[0], r[0], p);
                  end

    // R12: second start in mid-run is ignored
    start = 1'b1; vl = VLW'(5); pred = '1; inv = 1'b0; rc = 1'b0;
    incl = 1'b0; cmp = 1'b0; cond = 4'hF;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      start = (k == 2);
      vl = (k == 2) ? VLW'(2) : VLW'(5);
      #0.5;
      check("R12", elem, k, "index with stray start");
    end
    start = 1'b0;
    @(negedge clk);
    check("R12", done, 1, "done after stray start");
    check("R12", vl_out, 5, "length kept after stray start");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule